// File: doc/BRIEF.md
# Extension-Slot Address and Move Executor

This block carries out the small side operation that a 16-bit instruction may hold in its low byte when the main opcode leaves that byte unused. It keeps four 16-bit address pointers and four matching 16-bit step registers. It reads accumulator-low values through a register-file read port and writes auxiliary registers through a register-file write port. It also drives a single data-memory port that uses a request/acknowledge handshake. The main-opcode datapath presents the low byte together with `ext_en`. The block then performs at most one action and raises `done` for one cycle. It never touches the program counter.

The operations are: step a pointer down by one, step it up by one, add its step register to it, copy an accumulator-low value into an auxiliary-low register, store an accumulator-low value through a pointer, and load a word through a pointer into an auxiliary register. After a store or a load, the pointer moves either by one or by its step register, and bit 2 of the byte chooses which. The main datapath can preload the pointers and step registers while the block is idle. All pointers are visible on output buses.

The controller has five states. IDLE waits for `ext_en` and latches the decoded byte (IDLE to EXEC). In EXEC, a step action updates its pointer and a no-action byte does nothing; both go to DONE. A move samples the register file and goes to WB. A store samples the register file and goes to MEM, and a load goes straight to MEM. MEM holds the memory request until `dm_ack`. On the acknowledge cycle it post-modifies the pointer, then goes to WB for a load or to DONE for a store. WB writes the auxiliary register and goes to DONE. DONE raises `done` for one cycle and returns to IDLE.

Top module: `xslot_exec`

## Requirements
- R1: After reset, every pointer and step register reads zero, and `done`, `dm_req` and `rf_wr_en` are low.
- R2: Byte 000001rr decrements pointer rr, 000010rr increments it, and 000011rr adds step register rr to it. All arithmetic wraps modulo 2^16.
- R3: Byte 0001ddss writes the accumulator-low value selected by ss (`rf_rd_sel`=ss) to auxiliary register dd (`rf_wr_sel`={0,dd}). No memory access takes place.
- R4: Byte 001ssmdd writes accumulator-low ss to memory at the value pointer dd held before the operation. Only after that does the pointer change. No register-file write takes place.
- R5: Byte 01dddmss reads memory at the value pointer ss held before the operation and writes that word to auxiliary register ddd (`rf_wr_sel`=ddd). It makes exactly one memory request.
- R6: For store and load, m=0 (bit 2) adds one to the pointer and m=1 adds the matching step register. The result wraps modulo 2^16.
- R7: Byte 00000000, bytes 000000rr with rr nonzero, and any byte with bit 7 set perform no action. `done` still pulses, but there is no memory request, no register-file write and no pointer change.
- R8: Each accepted byte produces exactly one single-cycle `done`. An `ext_en` that arrives while an operation is in progress is ignored.
- R9: A preload (`ptr_ld_en`, `ptr_ld_sel` 0..3 = pointer, 4..7 = step register) takes effect only when the block is idle. A preload while busy is ignored.
- R10: While `dm_req` is high and `dm_ack` is low, the memory address, the write enable, the write data and all pointers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | Low byte is valid and should run |
| ext_byte | input | 8 | Extension low byte |
| done | output | 1 | One-cycle completion pulse |
| ptr_ld_en | input | 1 | Preload strobe |
| ptr_ld_sel | input | 3 | Preload target: 0..3 pointer, 4..7 step register |
| ptr_ld_data | input | 16 | Preload value |
| ar_out | output | 64 | Pointers, pointer k at bits 16k+15..16k |
| ix_out | output | 64 | Step registers, same packing |
| rf_rd_sel | output | 2 | Accumulator-low select |
| rf_rd_data | input | 16 | Accumulator-low value for rf_rd_sel |
| rf_wr_en | output | 1 | Auxiliary register write strobe |
| rf_wr_sel | output | 3 | Auxiliary register index |
| rf_wr_data | output | 16 | Auxiliary register write value |
| dm_req | output | 1 | Memory request |
| dm_we | output | 1 | Memory write (1) or read (0) |
| dm_addr | output | 16 | Memory address |
| dm_wdata | output | 16 | Memory write data |
| dm_ack | input | 1 | Memory acknowledge |
| dm_rdata | input | 16 | Memory read data, valid with dm_ack |

## Verification
A wrong pointer value shows up on `ar_out` in the cycle after the faulty update. It also appears on `dm_addr` at the next store or load through that pointer, so the bench compares the pointer buses after every operation. A mis-decoded byte or a stuck state appears within a few cycles as a missing or doubled `done`, an unexpected memory request or register write, or the wrong `rf_wr_sel`. Random memory latencies exercise the MEM wait. Any value that changes during a wait breaks the hold rules at once.

// File: rtl/xslot_pkg.sv
package xslot_pkg;

    localparam int XS_DW = 16;
    localparam int XS_PN = 4;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_STEP,
        OPK_MOVE,
        OPK_STORE,
        OPK_LOAD
    } opk_e;

    typedef enum logic [1:0] {
        STP_DEC,
        STP_INC,
        STP_IDX
    } step_e;

    // Field widths follow the fixed low-byte encoding.
    typedef struct packed {
        opk_e       kind;
        step_e      step;
        logic [1:0] ptr;
        logic [1:0] src;
        logic [2:0] dst;
    } xop_t;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_EXEC,
        XS_MEM,
        XS_WB,
        XS_DONE
    } xs_state_e;

endpackage

// File: rtl/xslot_decode.sv
module xslot_decode
    import xslot_pkg::*;
(
    input  logic [7:0] ext_byte,
    output xop_t       op
);

    always_comb begin
        op.kind = OPK_NONE;
        op.step = ext_byte[2] ? STP_IDX : STP_INC;
        op.ptr  = ext_byte[1:0];
        op.src  = ext_byte[4:3];
        op.dst  = ext_byte[5:3];
        if (ext_byte[7]) begin
            op.kind = OPK_NONE;
        end else if (ext_byte[6]) begin
            op.kind = OPK_LOAD;
        end else if (ext_byte[5]) begin
            op.kind = OPK_STORE;
        end else if (ext_byte[4]) begin
            op.kind = OPK_MOVE;
            op.src  = ext_byte[1:0];
            op.dst  = {1'b0, ext_byte[3:2]};
        end else begin
            unique case (ext_byte[3:2])
                2'b00: op.kind = OPK_NONE;
                2'b01: begin op.kind = OPK_STEP; op.step = STP_DEC; end
                2'b10: begin op.kind = OPK_STEP; op.step = STP_INC; end
                default: begin op.kind = OPK_STEP; op.step = STP_IDX; end
            endcase
        end
    end

endmodule

// File: rtl/xslot_ptrs.sv
module xslot_ptrs
    import xslot_pkg::*;
#(
    parameter int DW = XS_DW,
    parameter int PN = XS_PN,
    localparam int PW = $clog2(PN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_en,
    input  logic [PW-1:0]   upd_sel,
    input  step_e           upd_step,
    input  logic            ld_en,
    input  logic [PW:0]     ld_sel,
    input  logic [DW-1:0]   ld_data,
    output logic [DW-1:0]   sel_ar,
    output logic [PN*DW-1:0] ar_flat,
    output logic [PN*DW-1:0] ix_flat
);

    logic [DW-1:0] ar_q [PN];
    logic [DW-1:0] ix_q [PN];

    for (genvar g = 0; g < PN; g++) begin : g_slot
        logic [DW-1:0] nxt;

        always_comb begin
            unique case (upd_step)
                STP_DEC: nxt = ar_q[g] - DW'(1);
                STP_INC: nxt = ar_q[g] + DW'(1);
                STP_IDX: nxt = ar_q[g] + ix_q[g];
                default: nxt = ar_q[g];
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ar_q[g] <= '0;
            end else if (ld_en && ld_sel == {1'b0, PW'(g)}) begin
                ar_q[g] <= ld_data;
            end else if (upd_en && upd_sel == PW'(g)) begin
                ar_q[g] <= nxt;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ix_q[g] <= '0;
            end else if (ld_en && ld_sel == {1'b1, PW'(g)}) begin
                ix_q[g] <= ld_data;
            end
        end

        assign ar_flat[g*DW +: DW] = ar_q[g];
        assign ix_flat[g*DW +: DW] = ix_q[g];
    end

    assign sel_ar = ar_q[upd_sel];

endmodule

// File: rtl/xslot_ctrl.sv
module xslot_ctrl
    import xslot_pkg::*;
#(
    parameter int DW = XS_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_en,
    input  logic [7:0]    ext_byte,
    input  logic [DW-1:0] sel_ar,
    input  logic [DW-1:0] rf_rd_data,
    input  logic          dm_ack,
    input  logic [DW-1:0] dm_rdata,
    output logic          done,
    output logic          idle,
    output logic          upd_en,
    output logic [1:0]    upd_sel,
    output step_e         upd_step,
    output logic [1:0]    rf_rd_sel,
    output logic          rf_wr_en,
    output logic [2:0]    rf_wr_sel,
    output logic [DW-1:0] rf_wr_data,
    output logic          dm_req,
    output logic          dm_we,
    output logic [DW-1:0] dm_addr,
    output logic [DW-1:0] dm_wdata
);

    xs_state_e     state, nxt_state;
    xop_t          dec_op, op_q;
    logic [DW-1:0] hold_q;

    xslot_decode dec_i (
        .ext_byte (ext_byte),
        .op       (dec_op)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= XS_IDLE;
        else        state <= nxt_state;
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            XS_IDLE: if (ext_en) nxt_state = XS_EXEC;
            XS_EXEC: begin
                unique case (op_q.kind)
                    OPK_MOVE:            nxt_state = XS_WB;
                    OPK_STORE, OPK_LOAD: nxt_state = XS_MEM;
                    default:             nxt_state = XS_DONE;
                endcase
            end
            XS_MEM: if (dm_ack) nxt_state = (op_q.kind == OPK_LOAD) ? XS_WB : XS_DONE;
            XS_WB:   nxt_state = XS_DONE;
            XS_DONE: nxt_state = XS_IDLE;
            default: nxt_state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            hold_q <= '0;
        end else begin
            if (state == XS_IDLE && ext_en) op_q <= dec_op;
            if (state == XS_EXEC) hold_q <= rf_rd_data;
            else if (state == XS_MEM && dm_ack && op_q.kind == OPK_LOAD) hold_q <= dm_rdata;
        end
    end

    always_comb begin
        done       = (state == XS_DONE);
        idle       = (state == XS_IDLE);
        dm_req     = (state == XS_MEM);
        dm_we      = (op_q.kind == OPK_STORE);
        dm_addr    = sel_ar;
        dm_wdata   = hold_q;
        rf_rd_sel  = op_q.src;
        rf_wr_en   = (state == XS_WB);
        rf_wr_sel  = op_q.dst;
        rf_wr_data = hold_q;
        upd_sel    = op_q.ptr;
        upd_step   = op_q.step;
        upd_en     = (state == XS_EXEC && op_q.kind == OPK_STEP)
                   || (state == XS_MEM && dm_ack);
    end

endmodule

// File: rtl/xslot_exec.sv
module xslot_exec
    import xslot_pkg::*;
#(
    parameter int DW = XS_DW,
    parameter int PN = XS_PN,
    localparam int PW = $clog2(PN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_en,
    input  logic [7:0]       ext_byte,
    output logic             done,
    input  logic             ptr_ld_en,
    input  logic [PW:0]      ptr_ld_sel,
    input  logic [DW-1:0]    ptr_ld_data,
    output logic [PN*DW-1:0] ar_out,
    output logic [PN*DW-1:0] ix_out,
    output logic [1:0]       rf_rd_sel,
    input  logic [DW-1:0]    rf_rd_data,
    output logic             rf_wr_en,
    output logic [2:0]       rf_wr_sel,
    output logic [DW-1:0]    rf_wr_data,
    output logic             dm_req,
    output logic             dm_we,
    output logic [DW-1:0]    dm_addr,
    output logic [DW-1:0]    dm_wdata,
    input  logic             dm_ack,
    input  logic [DW-1:0]    dm_rdata
);

    logic          idle;
    logic          upd_en;
    logic [1:0]    upd_sel;
    step_e         upd_step;
    logic [DW-1:0] sel_ar;

    xslot_ctrl #(.DW(DW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_en     (ext_en),
        .ext_byte   (ext_byte),
        .sel_ar     (sel_ar),
        .rf_rd_data (rf_rd_data),
        .dm_ack     (dm_ack),
        .dm_rdata   (dm_rdata),
        .done       (done),
        .idle       (idle),
        .upd_en     (upd_en),
        .upd_sel    (upd_sel),
        .upd_step   (upd_step),
        .rf_rd_sel  (rf_rd_sel),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_sel  (rf_wr_sel),
        .rf_wr_data (rf_wr_data),
        .dm_req     (dm_req),
        .dm_we      (dm_we),
        .dm_addr    (dm_addr),
        .dm_wdata   (dm_wdata)
    );

    xslot_ptrs #(.DW(DW), .PN(PN)) ptrs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_sel  (PW'(upd_sel)),
        .upd_step (upd_step),
        .ld_en    (ptr_ld_en && idle),
        .ld_sel   (ptr_ld_sel),
        .ld_data  (ptr_ld_data),
        .sel_ar   (sel_ar),
        .ar_flat  (ar_out),
        .ix_flat  (ix_out)
    );

endmodule

// File: rtl/xslot_exec_chk.sv
module xslot_exec_chk #(
    parameter int DW = 16,
    parameter int PN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             rf_wr_en,
    input logic             dm_req,
    input logic             dm_we,
    input logic             dm_ack,
    input logic [DW-1:0]    dm_addr,
    input logic [DW-1:0]    dm_wdata,
    input logic [PN*DW-1:0] ar_out
);

    // R8: completion never lasts two cycles
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: request fields hold while waiting
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && !dm_ack) |=> (dm_req && $stable(dm_addr) && $stable(dm_we) && $stable(dm_wdata)));

    // R4: pointers keep the pre-modify value until the access completes
    p_ptr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && !dm_ack) |=> $stable(ar_out));

    // R5: one access per operation
    p_ack_ends_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && dm_ack) |=> !dm_req);

    // R3: a register write is followed directly by completion
    p_wb_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> done);

endmodule

bind xslot_exec xslot_exec_chk #(.DW(DW), .PN(PN)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .rf_wr_en (rf_wr_en),
    .dm_req   (dm_req),
    .dm_we    (dm_we),
    .dm_ack   (dm_ack),
    .dm_addr  (dm_addr),
    .dm_wdata (dm_wdata),
    .ar_out   (ar_out)
);

// File: tb/xslot_exec_tb_top.sv
module xslot_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic [7:0]  ext_byte = '0;
    logic        done;
    logic        ptr_ld_en = 1'b0;
    logic [2:0]  ptr_ld_sel = '0;
    logic [15:0] ptr_ld_data = '0;
    logic [63:0] ar_out, ix_out;
    logic [1:0]  rf_rd_sel;
    logic [15:0] rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_sel;
    logic [15:0] rf_wr_data;
    logic        dm_req, dm_we;
    logic [15:0] dm_addr, dm_wdata;
    logic        dm_ack = 1'b0;
    logic [15:0] dm_rdata = '0;

    always #10 clk = ~clk;

    xslot_exec dut_i (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .ext_byte(ext_byte), .done(done),
        .ptr_ld_en(ptr_ld_en), .ptr_ld_sel(ptr_ld_sel), .ptr_ld_data(ptr_ld_data),
        .ar_out(ar_out), .ix_out(ix_out), .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_ack(dm_ack), .dm_rdata(dm_rdata)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    logic [15:0] acc [4];
    logic [15:0] m_ar [4];
    logic [15:0] m_ix [4];
    assign rf_rd_data = acc[rf_rd_sel];

    int st_cnt = 0, ld_cnt = 0, wr_cnt = 0, done_cnt = 0;
    logic [15:0] st_addr, st_data, ld_addr, wr_dat_q;
    logic [2:0]  wr_sel_q;
    int lat_set = 0, lat_left = 0;

    function automatic logic [15:0] rd_pattern(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] next_ptr(input logic [15:0] cur, input logic [15:0] ix, input bit use_ix);
        return use_ix ? cur + ix : cur + 16'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder
    initial forever begin
        @(negedge clk);
        if (dm_ack) dm_ack = 1'b0;
        else if (dm_req) begin
            if (lat_left == 0) begin
                dm_ack = 1'b1;
                dm_rdata = rd_pattern(dm_addr);
                if (dm_we) begin st_cnt++; st_addr = dm_addr; st_data = dm_wdata; end
                else begin ld_cnt++; ld_addr = dm_addr; end
                lat_left = lat_set;
            end else lat_left--;
        end
    end

    // output monitor
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (done) done_cnt++;
            if (rf_wr_en) begin wr_cnt++; wr_sel_q = rf_wr_sel; wr_dat_q = rf_wr_data; end
        end
    end

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int k = 0; k < 4; k++) f[k*16 +: 16] = m_ar[k];
        return f;
    endfunction

    function automatic logic [63:0] model_ix();
        logic [63:0] f;
        for (int k = 0; k < 4; k++) f[k*16 +: 16] = m_ix[k];
        return f;
    endfunction

    task automatic preload(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        ptr_ld_en = 1'b1; ptr_ld_sel = sel; ptr_ld_data = val;
        @(negedge clk);
        ptr_ld_en = 1'b0;
        if (sel[2]) m_ix[sel[1:0]] = val; else m_ar[sel[1:0]] = val;
    endtask

    // expected-effect variables
    bit e_st, e_ld, e_wr;
    logic [15:0] e_addr, e_sdat, e_wdat;
    logic [2:0] e_wsel;
    string e_req, e_preq;

    task automatic model_op(input logic [7:0] b);
        logic [1:0] p;
        e_st = 0; e_ld = 0; e_wr = 0; e_req = "R7"; e_preq = "R7";
        p = b[1:0];
        if (b[7]) begin
        end else if (b[6]) begin
            e_ld = 1; e_addr = m_ar[p]; e_wr = 1; e_wsel = b[5:3];
            e_wdat = rd_pattern(m_ar[p]);
            m_ar[p] = next_ptr(m_ar[p], m_ix[p], b[2]);
            e_req = "R5"; e_preq = "R6";
        end else if (b[5]) begin
            e_st = 1; e_addr = m_ar[p]; e_sdat = acc[b[4:3]];
            m_ar[p] = next_ptr(m_ar[p], m_ix[p], b[2]);
            e_req = "R4"; e_preq = "R6";
        end else if (b[4]) begin
            e_wr = 1; e_wsel = {1'b0, b[3:2]}; e_wdat = acc[b[1:0]];
            e_req = "R3"; e_preq = "R3";
        end else begin
            case (b[3:2])
                2'b01: begin m_ar[p] = m_ar[p] - 16'd1; e_req = "R2"; e_preq = "R2"; end
                2'b10: begin m_ar[p] = m_ar[p] + 16'd1; e_req = "R2"; e_preq = "R2"; end
                2'b11: begin m_ar[p] = m_ar[p] + m_ix[p]; e_req = "R2"; e_preq = "R2"; end
                default: ;
            endcase
        end
    endtask

    int s_st, s_ld, s_wr, s_dn;

    task automatic issue(input logic [7:0] b);
        s_st = st_cnt; s_ld = ld_cnt; s_wr = wr_cnt; s_dn = done_cnt;
        model_op(b);
        @(negedge clk);
        lat_left = lat_set;
        ext_en = 1'b1; ext_byte = b;
        @(negedge clk);
        ext_en = 1'b0;
    endtask

    task automatic finish_op();
        bit got = 0;
        for (int i = 0; i < 40; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        @(negedge clk);
        chk(got && done_cnt == s_dn + 1, "R8", 64'(done_cnt - s_dn), 64'd1);
        chk(st_cnt - s_st == int'(e_st), e_req, 64'(st_cnt - s_st), 64'(e_st));
        chk(ld_cnt - s_ld == int'(e_ld), e_req, 64'(ld_cnt - s_ld), 64'(e_ld));
        chk(wr_cnt - s_wr == int'(e_wr), e_req, 64'(wr_cnt - s_wr), 64'(e_wr));
        if (e_st) chk(st_addr == e_addr && st_data == e_sdat, "R4", {st_addr, st_data}, {e_addr, e_sdat});
        if (e_ld) chk(ld_addr == e_addr, "R5", 64'(ld_addr), 64'(e_addr));
        if (e_wr) chk(wr_sel_q == e_wsel && wr_dat_q == e_wdat, e_req, {wr_sel_q, wr_dat_q}, {e_wsel, e_wdat});
        chk(ar_out == model_flat(), e_preq, ar_out, model_flat());
    endtask

    task automatic run_op(input logic [7:0] b);
        issue(b);
        finish_op();
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 4; k++) begin acc[k] = 16'h1111 * (k + 1); m_ar[k] = '0; m_ix[k] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ar_out == 64'd0 && ix_out == 64'd0, "R1", ar_out, 64'd0);
        chk(!done && !dm_req && !rf_wr_en, "R1", {done, dm_req, rf_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 directed step cases with wrap
        run_op(8'h04);                                   // ar0 0 -> FFFF
        preload(3'd1, 16'hFFFF); run_op(8'h09);          // ar1 FFFF -> 0
        preload(3'd2, 16'h1000); preload(3'd6, 16'h0020);
        run_op(8'h0E);                                   // ar2 += ix2
        // R9 preload visible
        chk(ix_out[47:32] == 16'h0020, "R9", 64'(ix_out[47:32]), 64'h20);

        // R3 move
        run_op(8'h1B);
        // R4 / R6 store with index add
        preload(3'd5, 16'h0100); lat_set = 2;
        run_op(8'h3D);
        // R5 / R6 load with post-increment
        run_op(8'h7A);
        // R6 wrap with index add
        preload(3'd3, 16'hFFF0); preload(3'd7, 16'h0020); lat_set = 0;
        run_op(8'h47);

        // R7 no-action bytes
        run_op(8'h00); run_op(8'h80); run_op(8'hC5); run_op(8'h02); run_op(8'hFF);

        // R8 / R9 activity while busy is ignored
        lat_set = 4;
        issue(8'h20);
        @(negedge clk);
        ext_en = 1'b1; ext_byte = 8'h08;
        ptr_ld_en = 1'b1; ptr_ld_sel = 3'd0; ptr_ld_data = 16'hBEEF;
        @(negedge clk);
        ext_en = 1'b0; ptr_ld_en = 1'b0;
        finish_op();
        repeat (6) @(negedge clk);
        chk(done_cnt == s_dn + 1, "R8", 64'(done_cnt - s_dn), 64'd1);
        chk(ar_out == model_flat(), "R9", ar_out, model_flat());

        // random mix
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < 4; k++) acc[k] = 16'($urandom);
            lat_set = $urandom % 4;
            if ($urandom % 4 == 0) preload(3'($urandom), 16'($urandom));
            if ($urandom % 8 == 0) begin
                chk(ix_out == model_ix(), "R9", ix_out, model_ix());
            end
            run_op(8'($urandom));
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R8 watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule